// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block carries out the memory traffic that surrounds a trap. An interrupt arrives with an 8-bit vector. An exception arrives with a 3-bit number and a 32-bit operand. The sequencer fetches the handler address from the vector table and builds a stack frame. It then clears the interrupt-enable and stack-swap flags and loads the instruction pointer with the handler address. A return request reverses the frame: it restores the flags byte, then the instruction pointer, and, when the restored flags ask for it, the stack pointer.

The block holds the architectural stack pointer, the exception stack pointer, the instruction pointer and the 4-bit flags register. The surrounding core can overwrite them through a context-load port while the block is idle. Memory is reached through a single request port that moves either a 32-bit word or a byte. A request stays up until the memory answers with a one-cycle acknowledge. Read data is valid in the acknowledge cycle. Words travel little-endian.

Top module: `irq_frame_seq`

## Requirements
- R1: An interrupt with vector n reads its handler word from address 4*n. An exception with number k reads from 0x400 + 4*k.
- R2: When requests arrive in the same idle cycle, an exception beats an interrupt, and an interrupt beats a return.
- R3: An interrupt is accepted only while the interrupt-enable flag (flags bit 2) is set. Otherwise it leaves the registers and memory untouched.
- R4: With the swap flag (flags bit 3) clear, entry builds the frame below the old stack pointer SP. The instruction pointer goes as a word at SP-4, the flags as a byte at SP-5 (bits 7:4 zero), and the vector number (zero-extended) or exception operand as a word at SP-9. The final stack pointer is SP-9.
- R5: With the swap flag set, entry first writes the old stack pointer as a word at ESP-4, where ESP is the exception stack pointer. The stack pointer becomes ESP-4, and the R4 frame follows below it. The exception stack pointer register itself is unchanged.
- R6: A completed entry leaves the instruction pointer equal to the handler address. Flags bits 2 and 3 become zero, and bits 0 (zero) and 1 (carry) are preserved.
- R7: A handler word of zero raises missErr for one cycle. Nothing is written, and the stack pointer, instruction pointer and flags keep their values.
- R8: A return reads the flags byte at SP (low 4 bits), then the instruction-pointer word at SP+1. The stack pointer becomes SP+5. If the restored flags have bit 3 set, it then becomes the word read at SP+5.
- R9: Once raised, a memory request keeps its address, direction, size and write data stable until the acknowledge.
- R10: An exception number above 4 is ignored.
- R11: A context load takes effect only while idle. One presented during a sequence is ignored.
- R12: After reset the block is idle, and its registers hold the reset parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intReq | input | 1 | Interrupt request |
| intVec | input | 8 | Interrupt vector number |
| excReq | input | 1 | Exception request |
| excNum | input | 3 | Exception number 0..4 |
| excOperand | input | 32 | Word pushed last on exception entry |
| retReq | input | 1 | Return-from-trap request |
| ctxLoad | input | 1 | Load the register set from the ctx inputs |
| ctxSp | input | 32 | Stack pointer load value |
| ctxEsp | input | 32 | Exception stack pointer load value |
| ctxIp | input | 32 | Instruction pointer load value |
| ctxFlags | input | 4 | Flags load value |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memByte | output | 1 | 1 = byte access, 0 = word |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data, byte in bits 7:0 |
| memRdata | input | 32 | Read data, byte in bits 7:0 |
| memAck | input | 1 | One-cycle completion |
| busy | output | 1 | Sequence in progress |
| missErr | output | 1 | Pulse: handler address was zero |
| spOut | output | 32 | Stack pointer |
| espOut | output | 32 | Exception stack pointer |
| ipOut | output | 32 | Instruction pointer |
| flagsOut | output | 4 | Flags: 0 zero, 1 carry, 2 int enable, 3 swap |

## Verification
On every cycle, the assertions check the request hold rule and the zero upper bits of a byte write. They also check that a refused interrupt keeps the sequencer idle, that every table read stays inside the table, and that a zero handler leaves the registers alone. They further check that a finished entry clears the two flags and lands on the fetched handler. Only the bench scenarios show the exact frame contents and byte order for both stack layouts, the priority outcomes, and the stack-pointer arithmetic of both return shapes. They also show that late context loads and out-of-range exception numbers are ignored.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  localparam int FLAG_W  = 4;
  localparam int FL_IE   = 2;
  localparam int FL_SWAP = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_VEC, S_PSP, S_PIP, S_PFL, S_PVAL, S_RFL, S_RIP, S_RSP
  } seqState_e;

  typedef enum logic [2:0] {
    SP_HOLD, SP_ESP4, SP_DEC4, SP_DEC1, SP_INC1, SP_INC4, SP_LDRD
  } spOp_e;

  typedef enum logic [2:0] {A_VEC, A_ESP4, A_SP4, A_SP1, A_SP} addrSel_e;
  typedef enum logic [1:0] {D_SP, D_IP, D_FL, D_VAL} dataSel_e;

  typedef struct packed {
    logic     latch;
    logic     isExc;
    logic     ctxEn;
    logic     grabHandler;
    spOp_e    spOp;
    logic     flagsFromMem;
    logic     ipFromMem;
    logic     jump;
    addrSel_e addrSel;
    dataSel_e dataSel;
  } seqCtl_t;
endpackage

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
#(
  parameter int EXC_W   = 3,
  parameter int NUM_EXC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intReq,
  input  logic             excReq,
  input  logic [EXC_W-1:0] excNum,
  input  logic             retReq,
  input  logic             ctxLoad,
  input  logic             memAck,
  input  logic             rdZero,
  input  logic             flagIe,
  input  logic             flagSwap,
  output seqCtl_t          ctl,
  output logic             memReq,
  output logic             memWe,
  output logic             memByte,
  output logic             busy,
  output logic             missErr
);
  localparam logic [EXC_W:0] EXC_LIMIT = (EXC_W+1)'(NUM_EXC);

  seqState_e state, nextState;
  logic missSet;
  logic excValid;

  assign excValid = excReq && ({1'b0, excNum} < EXC_LIMIT);

  always_comb begin
    ctl         = '0;
    ctl.spOp    = SP_HOLD;
    ctl.addrSel = A_SP;
    ctl.dataSel = D_SP;
    nextState   = state;
    missSet     = 1'b0;
    case (state)
      S_IDLE: begin
        ctl.ctxEn = ctxLoad;
        if (excValid) begin
          ctl.latch = 1'b1; ctl.isExc = 1'b1; nextState = S_VEC;
        end else if (intReq && flagIe) begin
          ctl.latch = 1'b1; nextState = S_VEC;
        end else if (retReq) begin
          nextState = S_RFL;
        end
      end
      S_VEC: begin
        ctl.addrSel = A_VEC;
        if (memAck) begin
          if (rdZero) begin
            missSet = 1'b1; nextState = S_IDLE;
          end else begin
            ctl.grabHandler = 1'b1;
            nextState = flagSwap ? S_PSP : S_PIP;
          end
        end
      end
      S_PSP: begin
        ctl.addrSel = A_ESP4; ctl.dataSel = D_SP;
        if (memAck) begin ctl.spOp = SP_ESP4; nextState = S_PIP; end
      end
      S_PIP: begin
        ctl.addrSel = A_SP4; ctl.dataSel = D_IP;
        if (memAck) begin ctl.spOp = SP_DEC4; nextState = S_PFL; end
      end
      S_PFL: begin
        ctl.addrSel = A_SP1; ctl.dataSel = D_FL;
        if (memAck) begin ctl.spOp = SP_DEC1; nextState = S_PVAL; end
      end
      S_PVAL: begin
        ctl.addrSel = A_SP4; ctl.dataSel = D_VAL;
        if (memAck) begin
          ctl.spOp = SP_DEC4; ctl.jump = 1'b1; nextState = S_IDLE;
        end
      end
      S_RFL: begin
        if (memAck) begin
          ctl.spOp = SP_INC1; ctl.flagsFromMem = 1'b1; nextState = S_RIP;
        end
      end
      S_RIP: begin
        if (memAck) begin
          ctl.spOp = SP_INC4; ctl.ipFromMem = 1'b1;
          nextState = flagSwap ? S_RSP : S_IDLE;
        end
      end
      S_RSP: begin
        if (memAck) begin ctl.spOp = SP_LDRD; nextState = S_IDLE; end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      missErr <= 1'b0;
    end else begin
      state   <= nextState;
      missErr <= missSet;
    end
  end

  assign busy    = (state != S_IDLE);
  assign memReq  = busy;
  assign memWe   = (state == S_PSP) || (state == S_PIP) || (state == S_PFL) || (state == S_PVAL);
  assign memByte = (state == S_PFL) || (state == S_RFL);

  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && intReq && !flagIe && !excValid && !retReq) |=> !busy); // R3
  AST_BAD_EXC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && excReq && !excValid && !intReq && !retReq) |=> !busy); // R10
endmodule

// File: rtl/irqseq_dpath.sv
module irqseq_dpath
  import irqseq_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          VEC_W       = 8,
  parameter int          EXC_W       = 3,
  parameter int          NUM_EXC     = 5,
  parameter logic [DATA_W-1:0] EXC_BASE    = 32'h400,
  parameter logic [DATA_W-1:0] RESET_SP    = '0,
  parameter logic [DATA_W-1:0] RESET_ESP   = '0,
  parameter logic [DATA_W-1:0] RESET_IP    = '0,
  parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtl_t           ctl,
  input  logic [VEC_W-1:0]  intVec,
  input  logic [EXC_W-1:0]  excNum,
  input  logic [DATA_W-1:0] excOperand,
  input  logic [DATA_W-1:0] ctxSp,
  input  logic [DATA_W-1:0] ctxEsp,
  input  logic [DATA_W-1:0] ctxIp,
  input  logic [FLAG_W-1:0] ctxFlags,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] spQ,
  output logic [DATA_W-1:0] espQ,
  output logic [DATA_W-1:0] ipQ,
  output logic [FLAG_W-1:0] flagsQ
);
  localparam logic [DATA_W-1:0] TABLE_END = EXC_BASE + DATA_W'(4 * NUM_EXC);

  logic [DATA_W-1:0] handlerQ, valQ, vecAddrQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spQ <= RESET_SP; espQ <= RESET_ESP; ipQ <= RESET_IP; flagsQ <= RESET_FLAGS;
      handlerQ <= '0; valQ <= '0; vecAddrQ <= '0;
    end else begin
      if (ctl.ctxEn) begin
        spQ <= ctxSp; espQ <= ctxEsp; ipQ <= ctxIp; flagsQ <= ctxFlags;
      end
      if (ctl.latch) begin
        vecAddrQ <= ctl.isExc ? EXC_BASE + {{(DATA_W-EXC_W-2){1'b0}}, excNum, 2'b00}
                              : {{(DATA_W-VEC_W-2){1'b0}}, intVec, 2'b00};
        valQ     <= ctl.isExc ? excOperand : {{(DATA_W-VEC_W){1'b0}}, intVec};
      end
      if (ctl.grabHandler) handlerQ <= memRdata;
      case (ctl.spOp)
        SP_ESP4: spQ <= espQ - DATA_W'(4);
        SP_DEC4: spQ <= spQ - DATA_W'(4);
        SP_DEC1: spQ <= spQ - DATA_W'(1);
        SP_INC1: spQ <= spQ + DATA_W'(1);
        SP_INC4: spQ <= spQ + DATA_W'(4);
        SP_LDRD: spQ <= memRdata;
        default: ;
      endcase
      if (ctl.flagsFromMem) flagsQ <= memRdata[FLAG_W-1:0];
      if (ctl.ipFromMem)    ipQ    <= memRdata;
      if (ctl.jump) begin
        ipQ             <= handlerQ;
        flagsQ[FL_IE]   <= 1'b0;
        flagsQ[FL_SWAP] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (ctl.addrSel)
      A_VEC:   memAddr = vecAddrQ;
      A_ESP4:  memAddr = espQ - DATA_W'(4);
      A_SP4:   memAddr = spQ - DATA_W'(4);
      A_SP1:   memAddr = spQ - DATA_W'(1);
      default: memAddr = spQ;
    endcase
    case (ctl.dataSel)
      D_SP:    memWdata = spQ;
      D_IP:    memWdata = ipQ;
      D_FL:    memWdata = {{(DATA_W-FLAG_W){1'b0}}, flagsQ};
      default: memWdata = valQ;
    endcase
  end

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.addrSel == A_VEC) |-> (memAddr < TABLE_END && memAddr[1:0] == 2'b00)); // R1
  AST_ENTRY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jump |=> (ipQ == $past(handlerQ) && !flagsQ[FL_IE] && !flagsQ[FL_SWAP])); // R6
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irqseq_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          VEC_W       = 8,
  parameter int          EXC_W       = 3,
  parameter int          NUM_EXC     = 5,
  parameter logic [31:0] EXC_BASE    = 32'h400,
  parameter logic [31:0] RESET_SP    = 32'h0,
  parameter logic [31:0] RESET_ESP   = 32'h0,
  parameter logic [31:0] RESET_IP    = 32'h0,
  parameter logic [3:0]  RESET_FLAGS = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intReq,
  input  logic [VEC_W-1:0]  intVec,
  input  logic              excReq,
  input  logic [EXC_W-1:0]  excNum,
  input  logic [DATA_W-1:0] excOperand,
  input  logic              retReq,
  input  logic              ctxLoad,
  input  logic [DATA_W-1:0] ctxSp,
  input  logic [DATA_W-1:0] ctxEsp,
  input  logic [DATA_W-1:0] ctxIp,
  input  logic [3:0]        ctxFlags,
  output logic              memReq,
  output logic              memWe,
  output logic              memByte,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              busy,
  output logic              missErr,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] espOut,
  output logic [DATA_W-1:0] ipOut,
  output logic [3:0]        flagsOut
);
  seqCtl_t ctl;

  irqseq_ctrl #(.EXC_W(EXC_W), .NUM_EXC(NUM_EXC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .intReq(intReq), .excReq(excReq), .excNum(excNum),
    .retReq(retReq), .ctxLoad(ctxLoad), .memAck(memAck), .rdZero(memRdata == '0),
    .flagIe(flagsOut[FL_IE]), .flagSwap(flagsOut[FL_SWAP]), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .memByte(memByte), .busy(busy), .missErr(missErr)
  );

  irqseq_dpath #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .EXC_W(EXC_W), .NUM_EXC(NUM_EXC),
    .EXC_BASE(EXC_BASE[DATA_W-1:0]), .RESET_SP(RESET_SP[DATA_W-1:0]),
    .RESET_ESP(RESET_ESP[DATA_W-1:0]), .RESET_IP(RESET_IP[DATA_W-1:0]),
    .RESET_FLAGS(RESET_FLAGS)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .intVec(intVec), .excNum(excNum),
    .excOperand(excOperand), .ctxSp(ctxSp), .ctxEsp(ctxEsp), .ctxIp(ctxIp),
    .ctxFlags(ctxFlags), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .spQ(spOut), .espQ(espOut), .ipQ(ipOut), .flagsQ(flagsOut)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && $stable(memByte) && $stable(memWdata))); // R9
  AST_BYTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && memByte) |-> (memWdata[DATA_W-1:4] == '0)); // R4
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    missErr |-> ($stable(spOut) && $stable(ipOut) && $stable(flagsOut) && !busy)); // R7
endmodule

// File: tb/sim_irq_frame_seq.sv
`timescale 1ns/1ps
module sim_irq_frame_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intReq = 0, excReq = 0, retReq = 0, ctxLoad = 0;
  logic [7:0]  intVec = 0;
  logic [2:0]  excNum = 0;
  logic [31:0] excOperand = 0, ctxSp = 0, ctxEsp = 0, ctxIp = 0;
  logic [3:0]  ctxFlags = 0;
  logic memReq, memWe, memByte, busy, missErr;
  logic [31:0] memAddr, memWdata, spOut, espOut, ipOut;
  logic [31:0] memRdata = 0;
  logic memAck = 0;
  logic [3:0] flagsOut;

  always #2.5 clk = ~clk;

  irq_frame_seq #(.RESET_SP(32'h800), .RESET_ESP(32'hC00), .RESET_IP(32'hF0001234),
                  .RESET_FLAGS(4'h4)) u0 (
    .clk(clk), .rst_n(rst_n), .intReq(intReq), .intVec(intVec), .excReq(excReq),
    .excNum(excNum), .excOperand(excOperand), .retReq(retReq), .ctxLoad(ctxLoad),
    .ctxSp(ctxSp), .ctxEsp(ctxEsp), .ctxIp(ctxIp), .ctxFlags(ctxFlags),
    .memReq(memReq), .memWe(memWe), .memByte(memByte), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .busy(busy),
    .missErr(missErr), .spOut(spOut), .espOut(espOut), .ipOut(ipOut), .flagsOut(flagsOut)
  );

  logic [7:0] mem [0:4095];
  int lat = 0, waitCnt = 0, writeCnt = 0, missCnt = 0, cycles = 0;
  int nChk = 0, nFail = 0, holdViol = 0;
  logic pendQ = 0;
  logic [31:0] addrQ = 0, wdQ = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (memAck) memAck <= 1'b0;
    else if (memReq) begin
      if (waitCnt < lat) waitCnt <= waitCnt + 1;
      else begin
        waitCnt <= 0;
        memAck  <= 1'b1;
        if (memWe) begin
          writeCnt <= writeCnt + 1;
          mem[memAddr[11:0]] <= memWdata[7:0];
          if (!memByte) begin
            mem[memAddr[11:0]+12'd1] <= memWdata[15:8];
            mem[memAddr[11:0]+12'd2] <= memWdata[23:16];
            mem[memAddr[11:0]+12'd3] <= memWdata[31:24];
          end
        end else if (memByte) memRdata <= {24'h0, mem[memAddr[11:0]]};
        else memRdata <= {mem[memAddr[11:0]+12'd3], mem[memAddr[11:0]+12'd2],
                          mem[memAddr[11:0]+12'd1], mem[memAddr[11:0]]};
      end
    end
    if (missErr) missCnt <= missCnt + 1;
  end

  // R9 monitor: a pending request must look the same one cycle later
  always @(negedge clk) begin
    if (rst_n && pendQ && (!memReq || memAddr != addrQ || memWdata != wdQ)) holdViol++;
    pendQ = memReq && !memAck;
    addrQ = memAddr;
    wdQ   = memWdata;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  function automatic logic [31:0] rd32(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(int a, logic [31:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic loadCtx(logic [31:0] sp, logic [31:0] esp, logic [31:0] ip, logic [3:0] fl);
    @(negedge clk);
    ctxLoad = 1; ctxSp = sp; ctxEsp = esp; ctxIp = ip; ctxFlags = fl;
    @(negedge clk);
    ctxLoad = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    if (busy) chk("R9", "sequence timeout busy", 32'(busy), 32'h0);
    @(negedge clk);
  endtask

  task automatic raiseInt(logic [7:0] v);
    @(negedge clk); intReq = 1; intVec = v;
    @(negedge clk); intReq = 0;
    waitIdle();
  endtask

  task automatic raiseExc(logic [2:0] k, logic [31:0] op);
    @(negedge clk); excReq = 1; excNum = k; excOperand = op;
    @(negedge clk); excReq = 0;
    waitIdle();
  endtask

  task automatic raiseRet();
    @(negedge clk); retReq = 1;
    @(negedge clk); retReq = 0;
    waitIdle();
  endtask

  task automatic tReset();
    chk("R12", "sp", spOut, 32'h800);
    chk("R12", "esp", espOut, 32'hC00);
    chk("R12", "ip", ipOut, 32'hF0001234);
    chk("R12", "flags", 32'(flagsOut), 32'h4);
    chk("R12", "busy", 32'(busy), 32'h0);
  endtask

  task automatic tPlainEntry(string tag);
    loadCtx(32'h800, 32'hC00, 32'h11223344, 4'h7);
    raiseInt(8'h21);
    chk("R1", {tag, " handler ip"}, ipOut, 32'h2000);
    chk("R4", {tag, " ip word"}, rd32(32'h7FC), 32'h11223344);
    chk("R4", {tag, " flags byte"}, 32'(mem[32'h7FB]), 32'h07);
    chk("R4", {tag, " vector word"}, rd32(32'h7F7), 32'h21);
    chk("R4", {tag, " final sp"}, spOut, 32'h7F7);
    chk("R6", {tag, " flags after"}, 32'(flagsOut), 32'h3);
  endtask

  task automatic tSwapEntry();
    loadCtx(32'h900, 32'hC00, 32'h55667788, 4'hC);
    raiseExc(3'd2, 32'hDEADBEEF);
    chk("R5", "old sp word", rd32(32'hBFC), 32'h900);
    chk("R5", "ip word", rd32(32'hBF8), 32'h55667788);
    chk("R5", "flags byte", 32'(mem[32'hBF7]), 32'h0C);
    chk("R5", "operand word", rd32(32'hBF3), 32'hDEADBEEF);
    chk("R5", "final sp", spOut, 32'hBF3);
    chk("R5", "esp kept", espOut, 32'hC00);
    chk("R1", "exc handler", ipOut, 32'h3000);
    chk("R6", "flags cleared", 32'(flagsOut), 32'h0);
  endtask

  task automatic tMasked();
    int w;
    loadCtx(32'h800, 32'hC00, 32'h1, 4'h3);
    w = writeCnt;
    @(negedge clk); intReq = 1; intVec = 8'h21;
    repeat (6) @(negedge clk);
    intReq = 0;
    chk("R3", "busy", 32'(busy), 32'h0);
    chk("R3", "ip", ipOut, 32'h1);
    chk("R3", "writes", 32'(writeCnt - w), 32'h0);
  endtask

  task automatic tPriority();
    loadCtx(32'h800, 32'hC00, 32'hA, 4'h4);
    @(negedge clk); excReq = 1; excNum = 3'd0; excOperand = 32'h77; intReq = 1; intVec = 8'h21;
    @(negedge clk); excReq = 0; intReq = 0;
    waitIdle();
    chk("R2", "exc beats int ip", ipOut, 32'h4000);
    chk("R2", "exc operand pushed", rd32(32'h7F7), 32'h77);
    loadCtx(32'h800, 32'hC00, 32'hB, 4'h4);
    @(negedge clk); intReq = 1; intVec = 8'hFF; retReq = 1;
    @(negedge clk); intReq = 0; retReq = 0;
    waitIdle();
    chk("R2", "int beats ret ip", ipOut, 32'hAABBCCDD);
    chk("R2", "int vector pushed", rd32(32'h7F7), 32'hFF);
  endtask

  task automatic tMissing();
    int w, m;
    loadCtx(32'h800, 32'hC00, 32'h5, 4'h7);
    w = writeCnt; m = missCnt;
    raiseExc(3'd4, 32'h1);
    chk("R7", "miss pulses", 32'(missCnt - m), 32'h1);
    chk("R7", "writes", 32'(writeCnt - w), 32'h0);
    chk("R7", "sp", spOut, 32'h800);
    chk("R7", "ip", ipOut, 32'h5);
    chk("R7", "flags", 32'(flagsOut), 32'h7);
  endtask

  task automatic tBadExc();
    @(negedge clk); excReq = 1; excNum = 3'd5; excOperand = 32'h9;
    repeat (4) @(negedge clk);
    excReq = 0;
    chk("R10", "busy", 32'(busy), 32'h0);
    chk("R10", "ip", ipOut, 32'h5);
  endtask

  task automatic tReturns();
    mem[32'h600] = 8'h03; wr32(32'h601, 32'hCAFEF00D);
    loadCtx(32'h600, 32'hC00, 32'h0, 4'h0);
    raiseRet();
    chk("R8", "plain flags", 32'(flagsOut), 32'h3);
    chk("R8", "plain ip", ipOut, 32'hCAFEF00D);
    chk("R8", "plain sp", spOut, 32'h605);
    mem[32'h700] = 8'h0C; wr32(32'h701, 32'h12345678); wr32(32'h705, 32'hABC);
    loadCtx(32'h700, 32'hC00, 32'h0, 4'h0);
    raiseRet();
    chk("R8", "swap flags", 32'(flagsOut), 32'hC);
    chk("R8", "swap ip", ipOut, 32'h12345678);
    chk("R8", "swap sp", spOut, 32'hABC);
  endtask

  task automatic tLateLoad();
    loadCtx(32'h800, 32'hC00, 32'h13579BDF, 4'h4);
    @(negedge clk); intReq = 1; intVec = 8'h21;
    @(negedge clk); intReq = 0;
    ctxLoad = 1; ctxSp = 32'h100; ctxEsp = 32'h200; ctxIp = 32'h99; ctxFlags = 4'hF;
    @(negedge clk); ctxLoad = 0;
    waitIdle();
    chk("R11", "ip", ipOut, 32'h2000);
    chk("R11", "pushed ip", rd32(32'h7FC), 32'h13579BDF);
    chk("R11", "sp", spOut, 32'h7F7);
    chk("R11", "esp", espOut, 32'hC00);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    wr32(32'h84, 32'h2000);
    wr32(32'h3FC, 32'hAABBCCDD);
    wr32(32'h400, 32'h4000);
    wr32(32'h408, 32'h3000);
    wr32(32'h414, 32'h5555);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tReset();
    tPlainEntry("fast");
    tSwapEntry();
    tMasked();
    tPriority();
    tMissing();
    tBadExc();
    tReturns();
    tLateLoad();
    lat = 3;
    tPlainEntry("slow memory");
    chk("R9", "request hold violations", 32'(holdViol), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule